// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the command engine between a host and an in-system serial flash that uses its own command set. The host puts one request on a request/acknowledge port: read, page program, sector erase or status read. The sequencer turns it into one or more SPI frames in mode 0. Program data comes in as a byte stream that the block pulls from the host. Read data goes out as a byte stream with a valid strobe. The address arrives already translated into the device's page layout.

After an erase or a program, the block keeps sending status reads until the device reports ready. Only then does it acknowledge the host. If the device stays busy for too many polls, the block gives up and reports a timeout instead. Whole-device erase is not sent to the flash; the host must erase sector by sector, where one sector spans eight pages.

Coming out of reset, the block reads the status register once. It then publishes the page-mode bit from that reply, which an external address translator uses to pick between power-of-two and default page layout.

The controller is a single state machine with these states:
- `ST_BOOT`: start-up.
- `ST_IDLE`: waiting for a request.
- `ST_OPCODE`, `ST_ADDR`, `ST_DATA`, `ST_STATUS`: the byte phases of a frame.
- `ST_GAP`: chip select held high.
- `ST_RESP`: acknowledge.

Its transitions are:
- boot to opcode;
- idle to opcode, or idle to response for a refused command;
- opcode to address, or opcode to status byte;
- address to data, or address to gap;
- data to gap;
- status byte to gap;
- gap to idle after the boot read;
- gap to response;
- gap to opcode, for the first poll or the next poll;
- response to idle.

Top module: `sflash_seq`

## Requirements
- R1: Reset state:
  - `cs_n`=1, `sclk`=0, `ack`=0 and `init_done`=0.
  - After reset the block sends exactly one status frame: opcode 0xD7, then one reply byte, with no address.
  - It then raises `init_done` and drives `pow2_mode` from bit 0 of that reply. `pow2_mode` stays stable from then on.
  - No request is acknowledged before `init_done` is 1.
- R2: SPI mode 0 framing:
  - `sclk` idles low and toggles only while `cs_n` is low.
  - Bits go out on `mosi` most significant first and are sampled from `miso` before each rising edge.
  - One `sclk` period is `CLK_DIV` clocks.
- R3: `cs_n` stays high for at least `GAP_CLKS` (two or more) clocks between consecutive frames.
- R4: Read (`req_cmd`=0):
  - One frame: opcode 0x03, then three address bytes most significant first, then `req_len` data bytes with no dummy cycles.
  - Each data byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in order.
  - The request is acknowledged with `resp_err`=0 and no status polling.
- R5: Program (`req_cmd`=1):
  - One frame: opcode 0x82, the three address bytes, then `req_len` bytes.
  - Each byte is taken from `wr_data` in a cycle where `wr_take` is 1.
  - Status polling follows the frame.
- R6: Erase (`req_cmd`=2): one frame of opcode 0x50 and the three address bytes, with no data, followed by status polling.
- R7: Status polling after a program or erase:
  - Separate 0xD7 frames repeat until a reply has bit 7 set.
  - The acknowledge with `resp_err`=0 follows that ready reply.
  - `status_byte` holds the last reply.
- R8: If `POLL_LIMIT` consecutive poll replies all have bit 7 clear, the block sends no further poll and acknowledges with `resp_err`=2 (timeout).
- R9: Status (`req_cmd`=3): a single 0xD7 frame with one reply byte, no polling, and an acknowledge with `resp_err`=0 and the reply on `status_byte`.
- R10: Chip erase (`req_cmd`=4) and codes 5 to 7 send no frame at all and are acknowledged with `resp_err`=1 (refused).
- R11: `ack` is a single-cycle pulse, one per accepted request.
- R12: A read or program with `req_len`=0 has no data phase: no `rd_valid` or `wr_take` pulse, and the frame ends after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request, held until `ack` |
| req_cmd | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 chip erase (refused) |
| req_addr | input | 24 | Translated device address |
| req_len | input | LEN_W | Data byte count for read or program |
| ack | output | 1 | One-cycle completion pulse |
| resp_err | output | 2 | 0 ok, 1 refused, 2 poll timeout; valid with `ack` |
| status_byte | output | 8 | Last status reply |
| wr_data | input | 8 | Program byte stream |
| wr_take | output | 1 | `wr_data` consumed at this clock edge |
| rd_data | output | 8 | Read byte stream |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| init_done | output | 1 | Start-up status read complete |
| pow2_mode | output | 1 | Page-mode bit captured at start-up |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume the host behaves as follows:
- It keeps `req` and its fields steady until it sees `ack`, and lowers `req` before the next clock edge.
- It presents a valid byte on `wr_data` whenever `wr_take` can rise.
- The flash side changes `miso` only after falling `sclk` edges.

The bench meets these assumptions in two ways. It drives requests and releases them on falling clock edges. It also includes a responder that shifts its reply on falling serial-clock edges, and whose busy period after a program or erase is set per test.

// File: rtl/sflash_seq_pkg.sv
package sflash_seq_pkg;

    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_PROGRAM = 8'h82;
    localparam logic [7:0] OP_ERASE   = 8'h50;
    localparam logic [7:0] OP_STATUS  = 8'hD7;

    localparam logic [2:0] CMD_READ    = 3'd0;
    localparam logic [2:0] CMD_PROGRAM = 3'd1;
    localparam logic [2:0] CMD_ERASE   = 3'd2;
    localparam logic [2:0] CMD_STATUS  = 3'd3;

    localparam logic [1:0] ERR_OK      = 2'd0;
    localparam logic [1:0] ERR_REJECT  = 2'd1;
    localparam logic [1:0] ERR_TIMEOUT = 2'd2;

    localparam int STS_READY_BIT = 7;
    localparam int STS_POW2_BIT  = 0;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_STATUS,
        ST_GAP,
        ST_RESP
    } state_e;

    typedef enum logic [1:0] {
        FK_BOOT,
        FK_HOST,
        FK_POLL
    } frame_e;

endpackage

// File: rtl/sflash_seq_ctr.sv
module sflash_seq_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/sflash_seq_shifter.sv
// One byte per start pulse, SPI mode 0: the output bit changes while sclk is low,
// the input bit is captured on the edge that raises sclk.
module sflash_seq_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic          busy;
    logic          high;
    logic [CW-1:0] tick;
    logic [2:0]    bitn;
    logic [7:0]    txs;
    logic [7:0]    rxs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            high <= 1'b0;
            tick <= '0;
            bitn <= '0;
            txs  <= '0;
            rxs  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                high <= 1'b0;
                tick <= '0;
                bitn <= '0;
                txs  <= tx_byte;
            end else if (busy) begin
                if (tick == CW'(HALF - 1)) begin
                    tick <= '0;
                    if (!high) begin
                        high <= 1'b1;
                        rxs  <= {rxs[6:0], miso};
                    end else begin
                        high <= 1'b0;
                        txs  <= {txs[6:0], 1'b0};
                        if (bitn == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end
                end else begin
                    tick <= tick + CW'(1);
                end
            end
        end
    end

    assign sclk    = busy & high;
    assign mosi    = txs[7];
    assign rx_byte = rxs;

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq #(
    parameter int CLK_DIV    = 4,
    parameter int POLL_LIMIT = 16,
    parameter int GAP_CLKS   = 2,
    parameter int LEN_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [2:0]       req_cmd,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             ack,
    output logic [1:0]       resp_err,
    output logic [7:0]       status_byte,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             init_done,
    output logic             pow2_mode,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);

    import sflash_seq_pkg::*;

    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int GW = $clog2(GAP_CLKS + 1);

    state_e           st, nxt;
    frame_e           kind;
    logic             issued;
    logic [2:0]       cur_cmd;
    logic [23:0]      cur_addr;
    logic [LEN_W-1:0] cur_len;

    logic             sh_start, sh_done;
    logic [7:0]       sh_tx, sh_rx;
    logic             bc_clr, bc_inc, pc_clr, pc_inc;
    logic [LEN_W-1:0] bc_q;
    logic [PW-1:0]    pc_q;
    logic [GW-1:0]    gap_q;
    logic             byte_st, stat_frame, mutating, last_poll;

    sflash_seq_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
        .miso(miso), .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
    );

    sflash_seq_ctr #(.W(LEN_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(bc_clr), .inc(bc_inc), .q(bc_q)
    );

    sflash_seq_ctr #(.W(PW)) u_polls (
        .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .q(pc_q)
    );

    sflash_seq_ctr #(.W(GW)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(st != ST_GAP), .inc(st == ST_GAP), .q(gap_q)
    );

    assign stat_frame = (kind != FK_HOST) || (cur_cmd == CMD_STATUS);
    assign mutating   = (cur_cmd == CMD_PROGRAM) || (cur_cmd == CMD_ERASE);
    assign last_poll  = (pc_q == PW'(POLL_LIMIT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_BOOT;
        else        st <= nxt;
    end

    // next state and counter control
    always_comb begin
        nxt    = st;
        bc_clr = 1'b0;
        bc_inc = 1'b0;
        pc_clr = 1'b0;
        pc_inc = 1'b0;
        unique case (st)
            ST_BOOT:   nxt = ST_OPCODE;
            ST_IDLE: begin
                if (req) nxt = (req_cmd > CMD_STATUS) ? ST_RESP : ST_OPCODE;
            end
            ST_OPCODE: begin
                if (sh_done) begin
                    bc_clr = 1'b1;
                    nxt    = stat_frame ? ST_STATUS : ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (sh_done) begin
                    if (bc_q == LEN_W'(2)) begin
                        bc_clr = 1'b1;
                        nxt    = (cur_cmd == CMD_ERASE || cur_len == '0) ? ST_GAP : ST_DATA;
                    end else begin
                        bc_inc = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (sh_done) begin
                    if (bc_q == cur_len - LEN_W'(1)) nxt = ST_GAP;
                    else                            bc_inc = 1'b1;
                end
            end
            ST_STATUS: begin
                if (sh_done) nxt = ST_GAP;
            end
            ST_GAP: begin
                if (gap_q == GW'(GAP_CLKS - 1)) begin
                    unique case (kind)
                        FK_BOOT: nxt = ST_IDLE;
                        FK_HOST: begin
                            if (mutating) begin
                                pc_clr = 1'b1;
                                nxt    = ST_OPCODE;
                            end else begin
                                nxt = ST_RESP;
                            end
                        end
                        FK_POLL: begin
                            if (status_byte[STS_READY_BIT] || last_poll) begin
                                nxt = ST_RESP;
                            end else begin
                                pc_inc = 1'b1;
                                nxt    = ST_OPCODE;
                            end
                        end
                        default: nxt = ST_IDLE;
                    endcase
                end
            end
            ST_RESP:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // request, status and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind        <= FK_BOOT;
            issued      <= 1'b0;
            cur_cmd     <= '0;
            cur_addr    <= '0;
            cur_len     <= '0;
            status_byte <= '0;
            pow2_mode   <= 1'b0;
            init_done   <= 1'b0;
            resp_err    <= ERR_OK;
        end else begin
            if (sh_start)     issued <= 1'b1;
            else if (sh_done) issued <= 1'b0;
            if (st == ST_IDLE && req) begin
                cur_cmd  <= req_cmd;
                cur_addr <= req_addr;
                cur_len  <= req_len;
                kind     <= FK_HOST;
                resp_err <= (req_cmd > CMD_STATUS) ? ERR_REJECT : ERR_OK;
            end
            if (st == ST_STATUS && sh_done) status_byte <= sh_rx;
            if (st == ST_GAP && nxt != ST_GAP) begin
                unique case (kind)
                    FK_BOOT: begin
                        pow2_mode <= status_byte[STS_POW2_BIT];
                        init_done <= 1'b1;
                    end
                    FK_HOST: if (mutating) kind <= FK_POLL;
                    FK_POLL: begin
                        if (!status_byte[STS_READY_BIT] && last_poll) resp_err <= ERR_TIMEOUT;
                    end
                    default: kind <= FK_HOST;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        byte_st  = (st == ST_OPCODE) || (st == ST_ADDR) || (st == ST_DATA) || (st == ST_STATUS);
        cs_n     = !byte_st;
        sh_start = byte_st && !issued;
        sh_tx    = 8'h00;
        unique case (st)
            ST_OPCODE: begin
                if (stat_frame)                  sh_tx = OP_STATUS;
                else if (cur_cmd == CMD_READ)    sh_tx = OP_READ;
                else if (cur_cmd == CMD_PROGRAM) sh_tx = OP_PROGRAM;
                else                             sh_tx = OP_ERASE;
            end
            ST_ADDR: begin
                if (bc_q == LEN_W'(0))      sh_tx = cur_addr[23:16];
                else if (bc_q == LEN_W'(1)) sh_tx = cur_addr[15:8];
                else                        sh_tx = cur_addr[7:0];
            end
            ST_DATA:   sh_tx = (cur_cmd == CMD_PROGRAM) ? wr_data : 8'h00;
            default:   sh_tx = 8'h00;
        endcase
        wr_take  = (st == ST_DATA) && (cur_cmd == CMD_PROGRAM) && sh_start;
        rd_valid = (st == ST_DATA) && (cur_cmd == CMD_READ) && sh_done;
        rd_data  = sh_rx;
        ack      = (st == ST_RESP);
    end

endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       ack,
    input logic [1:0] resp_err,
    input logic [7:0] status_byte,
    input logic       init_done,
    input logic       pow2_mode,
    input logic [2:0] cur_cmd
);

    import sflash_seq_pkg::*;

    // R2: serial clock only inside a frame
    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R3: chip select stays high across a second clock
    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R11: acknowledge lasts one cycle
    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R1: nothing is acknowledged before start-up finishes
    a_r1_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ack);

    // R1: page-mode output frozen after start-up
    a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && $stable(pow2_mode)));

    // R10: a refused request is answered without a frame
    a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && resp_err == ERR_REJECT) |-> cs_n);

    // R7: a good answer to program or erase follows a ready reply
    a_r7_ready_before_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && resp_err == ERR_OK && (cur_cmd == CMD_PROGRAM || cur_cmd == CMD_ERASE))
        |-> status_byte[STS_READY_BIT]);

    // R8: a timeout answer follows a busy reply
    a_r8_timeout_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && resp_err == ERR_TIMEOUT) |-> !status_byte[STS_READY_BIT]);

endmodule

bind sflash_seq sflash_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .ack(ack),
    .resp_err(resp_err), .status_byte(status_byte), .init_done(init_done),
    .pow2_mode(pow2_mode), .cur_cmd(cur_cmd)
);

// File: tb/sflash_seq_bench.sv
module sflash_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PLIM       = 6;
    localparam int NV         = 9;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [23:0] addr;
        logic [9:0]  len;
        logic [7:0]  busy;
        logic [1:0]  err;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 24'h012345, 10'd5, 8'd0, 2'd0},
        '{3'd1, 24'h000420, 10'd4, 8'd2, 2'd0},
        '{3'd2, 24'h001080, 10'd0, 8'd3, 2'd0},
        '{3'd3, 24'h000000, 10'd0, 8'd0, 2'd0},
        '{3'd4, 24'h000000, 10'd0, 8'd0, 2'd1},
        '{3'd0, 24'hFFFFFF, 10'd1, 8'd0, 2'd0},
        '{3'd1, 24'h0ABCDE, 10'd0, 8'd0, 2'd0},
        '{3'd7, 24'h123456, 10'd3, 8'd0, 2'd1},
        '{3'd0, 24'h000010, 10'd0, 8'd0, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [23:0] req_addr = '0;
    logic [9:0] req_len = '0;
    logic       ack, wr_take, rd_valid, init_done, pow2_mode, sclk, cs_n, mosi, miso;
    logic [1:0] resp_err;
    logic [7:0] status_byte, rd_data, wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sflash_seq #(.CLK_DIV(4), .POLL_LIMIT(PLIM), .GAP_CLKS(2), .LEN_W(10)) u_sflash_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_len(req_len), .ack(ack), .resp_err(resp_err), .status_byte(status_byte),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .init_done(init_done), .pow2_mode(pow2_mode), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] rpat(input logic [23:0] a, input int k);
        return (a[7:0] + 8'(k)) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] wpat(input int k);
        return 8'(8'hA0 + k * 7);
    endfunction

    // program byte source
    int widx = 0;
    always @(posedge clk) if (rst_n && wr_take) widx <= widx + 1;
    assign wr_data = wpat(widx);

    // read byte sink
    int rcnt = 0;
    logic [7:0] rbuf [256];
    always @(negedge clk) if (rd_valid) begin
        rbuf[rcnt % 256] = rd_data;
        rcnt++;
    end

    // flash responder
    int         pow2_cfg = 1;
    int         busy_cfg = 0;
    int         busy_left = 0;
    int         m_frames = 0;
    int         m_polls = 0;
    int         m_bit = 0;
    int         m_byte = 0;
    int         stray = 0;
    logic [7:0] m_sh = '0;
    logic [7:0] m_opc = '0;
    logic [7:0] m_nxt = '0;
    logic [7:0] m_miso = '0;
    logic [23:0] m_addr = '0;
    logic [7:0] m_ops [256];
    logic [23:0] m_adrs [256];
    logic [7:0] m_prog [64];

    assign miso = m_miso[7];

    always @(negedge cs_n) begin
        m_bit = 0;
        m_byte = 0;
        m_frames++;
    end

    always @(posedge cs_n) begin
        if (m_opc == 8'h50 || m_opc == 8'h82) busy_left = busy_cfg;
        m_opc = 8'h00;
    end

    always @(posedge sclk) begin
        if (cs_n) begin
            stray++;
        end else begin
            m_sh = {m_sh[6:0], mosi};
            m_bit++;
            if (m_bit == 8) begin
                m_bit = 0;
                if (m_byte == 0) begin
                    m_opc = m_sh;
                    m_ops[m_frames % 256] = m_sh;
                    if (m_sh == 8'hD7) begin
                        m_polls++;
                        m_nxt = {(busy_left == 0), 6'b0, pow2_cfg[0]};
                        if (busy_left > 0) busy_left--;
                    end
                end else if (m_byte <= 3) begin
                    m_addr = {m_addr[15:0], m_sh};
                    if (m_byte == 3) m_adrs[m_frames % 256] = {m_addr[23:8], m_sh};
                    if (m_byte == 3 && m_opc == 8'h03) m_nxt = rpat(m_addr, 0);
                end else begin
                    if (m_opc == 8'h82 && m_byte - 4 < 64) m_prog[m_byte - 4] = m_sh;
                    if (m_opc == 8'h03) m_nxt = rpat(m_addr, m_byte - 3);
                end
                m_byte++;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (m_bit == 0) m_miso = m_nxt;
            else            m_miso = {m_miso[6:0], 1'b0};
        end
    end

    // chip-select high time between frames, in clocks
    int hi_run = 0;
    int min_gap = 1000;
    always @(negedge clk) begin
        if (cs_n) hi_run++;
        else begin
            if (hi_run != 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary();
        end
    end

    task automatic send(input logic [2:0] c, input logic [23:0] a, input logic [9:0] l,
                        output logic [1:0] got);
        @(negedge clk);
        req      = 1'b1;
        req_cmd  = c;
        req_addr = a;
        req_len  = l;
        while (!ack) @(negedge clk);
        got = resp_err;
        req = 1'b0;
        @(negedge clk);
        chk_eq("R11 ack single pulse", int'(ack), 0);
    endtask

    task automatic run_vec(input vec_t v);
        int f0, p0, r0, w0, exp_polls, l;
        logic [1:0] got;
        string tag;
        l = int'(v.len);
        unique case (v.cmd)
            3'd0:    tag = "R4";
            3'd1:    tag = "R5";
            3'd2:    tag = "R6";
            3'd3:    tag = "R9";
            default: tag = "R10";
        endcase
        busy_cfg = int'(v.busy);
        f0 = m_frames; p0 = m_polls; r0 = rcnt; w0 = widx;
        send(v.cmd, v.addr, v.len, got);
        chk_eq({tag, " response code"}, int'(got), int'(v.err));
        if (v.err == 2'd1) begin
            chk_eq("R10 no frame sent", m_frames - f0, 0);
        end else begin
            if (v.cmd == 3'd1 || v.cmd == 3'd2)
                exp_polls = (int'(v.busy) < PLIM) ? int'(v.busy) + 1 : PLIM;
            else if (v.cmd == 3'd3)
                exp_polls = 1;
            else
                exp_polls = 0;
            chk_eq({tag, " opcode"}, int'(m_ops[(f0 + 1) % 256]),
                   (v.cmd == 3'd0) ? 8'h03 : (v.cmd == 3'd1) ? 8'h82 : (v.cmd == 3'd2) ? 8'h50 : 8'hD7);
            if (v.cmd != 3'd3) chk_eq({tag, " address"}, int'(m_adrs[(f0 + 1) % 256]), int'(v.addr));
            if (v.cmd == 3'd3) begin
                chk_eq("R9 frames", m_frames - f0, 1);
                chk_eq("R9 status reply", int'(status_byte), {24'd0, 1'b1, 6'b0, pow2_cfg[0]});
            end else begin
                chk_eq("R7 status polls", m_polls - p0, exp_polls);
                chk_eq({tag, " frame count"}, m_frames - f0, 1 + exp_polls);
            end
            if (v.cmd == 3'd0) begin
                chk_eq(l == 0 ? "R12 read bytes" : "R4 read bytes", rcnt - r0, l);
                for (int k = 0; k < l; k++)
                    chk_eq("R4 read data", int'(rbuf[(r0 + k) % 256]), int'(rpat(v.addr, k)));
            end
            if (v.cmd == 3'd1) begin
                chk_eq(l == 0 ? "R12 program bytes" : "R5 program bytes", widx - w0, l);
                for (int k = 0; k < l; k++)
                    chk_eq("R5 program data", int'(m_prog[k]), int'(wpat(w0 + k)));
            end
        end
    endtask

    initial begin
        logic [1:0] got;
        int f0, p0;
        repeat (3) @(negedge clk);
        chk_eq("R1 reset cs_n", int'(cs_n), 1);
        chk_eq("R1 reset sclk", int'(sclk), 0);
        chk_eq("R1 reset ack", int'(ack), 0);
        chk_eq("R1 reset init_done", int'(init_done), 0);
        rst_n = 1'b1;
        while (!init_done) @(negedge clk);
        chk_eq("R1 start-up frames", m_frames, 1);
        chk_eq("R1 start-up opcode", int'(m_ops[1]), 8'hD7);
        chk_eq("R1 page mode bit", int'(pow2_mode), 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8: busy for exactly the poll budget -> timeout
        busy_cfg = PLIM; p0 = m_polls;
        send(3'd2, 24'h002100, 10'd0, got);
        chk_eq("R8 timeout code", int'(got), 2);
        chk_eq("R8 poll count", m_polls - p0, PLIM);
        // R7: ready on the last allowed poll -> success
        busy_cfg = PLIM - 1; p0 = m_polls;
        send(3'd1, 24'h000840, 10'd2, got);
        chk_eq("R7 last poll ready", int'(got), 0);
        chk_eq("R7 poll count at limit", m_polls - p0, PLIM);

        chk_eq("R2 sclk edges outside frames", stray, 0);
        checks++;
        if (min_gap < 2) begin
            errors++;
            $display("FAIL R3 cs_n gap actual=%0d expected>=2", min_gap);
        end

        // second start-up with the other page mode and a request waiting
        @(negedge clk);
        rst_n = 1'b0;
        pow2_cfg = 0;
        busy_cfg = 0;
        f0 = m_frames;
        req = 1'b1; req_cmd = 3'd3; req_addr = '0; req_len = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        while (!ack) @(negedge clk);
        chk_eq("R1 init before ack", int'(init_done), 1);
        req = 1'b0;
        chk_eq("R1 page mode bit clear", int'(pow2_mode), 0);
        chk_eq("R1 boot frame first", int'(m_ops[(f0 + 1) % 256]), 8'hD7);
        chk_eq("R1 frames for boot and request", m_frames - f0, 2);
        chk_eq("R9 status after restart", int'(status_byte), 8'h80);

        summary();
    end

endmodule